// File: doc/BRIEF.md
# UART FIFO DMA Event Generator

This block raises the two synchronization pulses that a DMA controller uses to service a UART whose receive and transmit queues are enabled. On the receive side it compares the current receive-queue occupancy with a threshold. A 2-bit selector in the FIFO control register picks that threshold. It also responds to the receiver's idle-timeout strobe. Whenever the character at the head of the receive queue is marked bad, it withholds the request. On the transmit side it fires when the last queued byte moves into the shift register. It also fires when the transmitter is released from its reset hold.

The block sits between the UART's queue bookkeeping and the DMA controller. Its pulses are one clock wide. They are neither stored nor retried. If a DMA channel is not listening when a pulse fires, that request is gone until a new qualifying condition occurs. The queues, the serializer, the timeout counter and the DMA engine are all outside this block. The block uses a synchronous, active-high reset.

Top module: `uart_fifo_dma_events`

## Requirements
- R1: The selector `rx_trig_sel` maps 2'b00 to 1, 2'b01 to 4, 2'b10 to 8 and 2'b11 to 14 characters. `rx_dma_evt` pulses on the clock edge after the cycle in which `rx_level` first becomes greater than or equal to the selected threshold.
- R2: A one-cycle high on `rx_timeout` produces an `rx_dma_evt` pulse on the next edge, even when `rx_level` is below the threshold.
- R3: While `rx_head_err` is high, no `rx_dma_evt` is produced, whether the cause is the threshold or a timeout.
- R4: A threshold condition that stays true produces only one pulse. A new threshold pulse needs one of two things first: `rx_level` drops below the threshold, or `rx_head_err` blocks the condition for at least one cycle.
- R5: `tx_dma_evt` pulses on the edge after `tx_pull` is high while `tx_level` equals 1, which leaves the queue empty. `tx_pull` with `tx_level` greater than 1 produces nothing.
- R6: `tx_dma_evt` pulses on the edge after `tx_run` goes from 0 (held in reset) to 1 (released).
- R7: While `fifo_en` is 0, both outputs stay low regardless of any other input.
- R8: Requests are not stored. A condition that arises while `fifo_en` is 0 produces no pulse when `fifo_en` later returns to 1 with that condition still present.
- R9: During synchronous reset, and on the edge after it, both outputs are low. Reset clears the record of the previous threshold state, so a threshold already met at reset release produces a pulse. Reset records the transmitter as already released, so a `tx_run` held at 1 produces none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO mode enable from the FIFO control register |
| rx_trig_sel | input | 2 | Receive threshold selector (FIFO control bits 7:6) |
| rx_level | input | RX_CNT_W (5) | Characters currently held in the receive queue |
| rx_head_err | input | 1 | Head character of the receive queue carries an error |
| rx_timeout | input | 1 | One-cycle receiver idle-timeout strobe |
| tx_pull | input | 1 | Strobe: a byte moves from the transmit queue to the shift register |
| tx_level | input | TX_CNT_W (5) | Transmit queue occupancy before the move |
| tx_run | input | 1 | Transmitter reset control: 0 held, 1 released |
| rx_dma_evt | output | 1 | Receive DMA request pulse |
| tx_dma_evt | output | 1 | Transmit DMA request pulse |

## Verification
The hardest case to reach is re-arming the receive threshold through the error flag, with no drop in occupancy. The stimulus holds the level above threshold with `rx_head_err` set for one cycle. It then clears the flag and expects a fresh pulse. A second hard case is a condition that arises while FIFO mode is off. The stimulus builds a full queue and a pending reset release with `fifo_en` low, then turns the mode back on with both still present, and checks that nothing fires. Switching the selector while the occupancy stays fixed walks each threshold without draining the queue.

// File: rtl/uart_dmaev_pkg.sv
package uart_dmaev_pkg;
   typedef enum logic [1:0] {
      TRIG_SEL_A = 2'b00,
      TRIG_SEL_B = 2'b01,
      TRIG_SEL_C = 2'b10,
      TRIG_SEL_D = 2'b11
   } trig_sel_e;

   localparam int unsigned NUM_TRIG = 4;
endpackage

// File: rtl/dmaev_rx_req.sv
module dmaev_rx_req
   import uart_dmaev_pkg::*;
#(
   parameter int unsigned CNT_W = 5,
   parameter int unsigned LVL_A = 1,
   parameter int unsigned LVL_B = 4,
   parameter int unsigned LVL_C = 8,
   parameter int unsigned LVL_D = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fifo_en,
   input  trig_sel_e        trig_sel,
   input  logic [CNT_W-1:0] level,
   input  logic             head_err,
   input  logic             timeout,
   output logic             evt
);
   localparam int unsigned LVLS [NUM_TRIG] = '{LVL_A, LVL_B, LVL_C, LVL_D};

   logic [NUM_TRIG-1:0] meet;
   logic                cond_raw;
   logic                cond_prev;

   for (genvar i = 0; i < NUM_TRIG; i++) begin : g_cmp
      assign meet[i] = (level >= CNT_W'(LVLS[i]));
   end

   assign cond_raw = meet[trig_sel] && !head_err;

   always_ff @(posedge clk) begin
      if (rst) begin
         evt       <= 1'b0;
         cond_prev <= 1'b0;
      end else begin
         cond_prev <= cond_raw;
         evt       <= fifo_en && ((cond_raw && !cond_prev) || (timeout && !head_err));
      end
   end

   assert_rx_cause_R2: assert property (@(posedge clk) disable iff (rst)
      evt |-> ($past(timeout) || $past(meet[trig_sel])));
   assert_rx_err_block_R3: assert property (@(posedge clk) disable iff (rst)
      evt |-> !$past(head_err));
   assert_rx_no_repeat_R4: assert property (@(posedge clk) disable iff (rst)
      (evt && !$past(timeout)) |=> (!evt || $past(timeout)));
   assert_rx_off_R7: assert property (@(posedge clk) disable iff (rst)
      evt |-> $past(fifo_en));
endmodule

// File: rtl/dmaev_tx_req.sv
module dmaev_tx_req #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fifo_en,
   input  logic             pull,
   input  logic [CNT_W-1:0] level,
   input  logic             run,
   output logic             evt
);
   logic drain;
   logic release_edge;
   logic run_prev;

   assign drain        = pull && (level == CNT_W'(1));
   assign release_edge = run && !run_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         evt      <= 1'b0;
         run_prev <= 1'b1;
      end else begin
         run_prev <= run;
         evt      <= fifo_en && (drain || release_edge);
      end
   end

   assert_tx_cause_R5: assert property (@(posedge clk) disable iff (rst)
      evt |-> (($past(pull) && $past(level) == CNT_W'(1)) || $past(run)));
   assert_tx_no_repeat_R6: assert property (@(posedge clk) disable iff (rst)
      (evt && !$past(pull)) |=> (!evt || $past(pull)));
   assert_tx_off_R7: assert property (@(posedge clk) disable iff (rst)
      evt |-> $past(fifo_en));
endmodule

// File: rtl/uart_fifo_dma_events.sv
module uart_fifo_dma_events
   import uart_dmaev_pkg::*;
#(
   parameter int unsigned RX_DEPTH = 16,
   parameter int unsigned TX_DEPTH = 16,
   parameter int unsigned LVL_A    = 1,
   parameter int unsigned LVL_B    = 4,
   parameter int unsigned LVL_C    = 8,
   parameter int unsigned LVL_D    = 14,
   localparam int unsigned RX_CNT_W = $clog2(RX_DEPTH + 1),
   localparam int unsigned TX_CNT_W = $clog2(TX_DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                fifo_en,
   input  logic [1:0]          rx_trig_sel,
   input  logic [RX_CNT_W-1:0] rx_level,
   input  logic                rx_head_err,
   input  logic                rx_timeout,
   input  logic                tx_pull,
   input  logic [TX_CNT_W-1:0] tx_level,
   input  logic                tx_run,
   output logic                rx_dma_evt,
   output logic                tx_dma_evt
);
   if (LVL_A == 0 || LVL_A > LVL_B || LVL_B > LVL_C || LVL_C > LVL_D) begin : g_bad_order
      $error("receive thresholds must be nonzero and ascending");
   end
   if (LVL_D > RX_DEPTH) begin : g_bad_depth
      $error("largest receive threshold exceeds receive depth");
   end
   if (TX_DEPTH < 1) begin : g_bad_tx
      $error("transmit depth must be at least 1");
   end

   dmaev_rx_req #(
      .CNT_W (RX_CNT_W),
      .LVL_A (LVL_A),
      .LVL_B (LVL_B),
      .LVL_C (LVL_C),
      .LVL_D (LVL_D)
   ) u_rx (
      .clk      (clk),
      .rst      (rst),
      .fifo_en  (fifo_en),
      .trig_sel (trig_sel_e'(rx_trig_sel)),
      .level    (rx_level),
      .head_err (rx_head_err),
      .timeout  (rx_timeout),
      .evt      (rx_dma_evt)
   );

   dmaev_tx_req #(
      .CNT_W (TX_CNT_W)
   ) u_tx (
      .clk     (clk),
      .rst     (rst),
      .fifo_en (fifo_en),
      .pull    (tx_pull),
      .level   (tx_level),
      .run     (tx_run),
      .evt     (tx_dma_evt)
   );

   assert_reset_quiet_R9: assert property (@(posedge clk)
      $past(rst) |-> (!rx_dma_evt && !tx_dma_evt));
endmodule

// File: tb/sim_uart_fifo_dma_events.sv
module sim_uart_fifo_dma_events;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       fifo_en = 1'b0;
   logic [1:0] rx_trig_sel = 2'b00;
   logic [4:0] rx_level = 5'd0;
   logic       rx_head_err = 1'b0;
   logic       rx_timeout = 1'b0;
   logic       tx_pull = 1'b0;
   logic [4:0] tx_level = 5'd0;
   logic       tx_run = 1'b1;
   logic       rx_dma_evt;
   logic       tx_dma_evt;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   uart_fifo_dma_events u0 (
      .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_trig_sel(rx_trig_sel),
      .rx_level(rx_level), .rx_head_err(rx_head_err), .rx_timeout(rx_timeout),
      .tx_pull(tx_pull), .tx_level(tx_level), .tx_run(tx_run),
      .rx_dma_evt(rx_dma_evt), .tx_dma_evt(tx_dma_evt)
   );

   typedef struct packed {
      logic [3:0] req;
      logic       en;
      logic [1:0] sel;
      logic [4:0] cnt;
      logic       err;
      logic       tmo;
      logic       ld;
      logic [4:0] txc;
      logic       run;
      logic       erx;
      logic       etx;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VECS [NV] = '{
      '{4'd9, 1'b1, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R9 idle after reset
      '{4'd1, 1'b1, 2'd0, 5'd1,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0}, // R1 threshold 1
      '{4'd4, 1'b1, 2'd0, 5'd1,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R4 held, no repeat
      '{4'd4, 1'b1, 2'd0, 5'd2,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R4 rising above
      '{4'd4, 1'b1, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R4 drop re-arms
      '{4'd1, 1'b1, 2'd1, 5'd3,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R1 below 4
      '{4'd1, 1'b1, 2'd1, 5'd4,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0}, // R1 threshold 4
      '{4'd4, 1'b1, 2'd1, 5'd5,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R4
      '{4'd1, 1'b1, 2'd2, 5'd5,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R1 below 8
      '{4'd1, 1'b1, 2'd2, 5'd8,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0}, // R1 threshold 8
      '{4'd1, 1'b1, 2'd3, 5'd13, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R1 below 14
      '{4'd1, 1'b1, 2'd3, 5'd14, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0}, // R1 threshold 14
      '{4'd3, 1'b1, 2'd3, 5'd15, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R3 error blocks
      '{4'd4, 1'b1, 2'd3, 5'd15, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0}, // R4 error cleared re-arms
      '{4'd2, 1'b1, 2'd3, 5'd0,  1'b0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0}, // R2 timeout below level
      '{4'd3, 1'b1, 2'd3, 5'd0,  1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R3 timeout blocked
      '{4'd5, 1'b1, 2'd3, 5'd0,  1'b0, 1'b0, 1'b1, 5'd3, 1'b1, 1'b0, 1'b0}, // R5 not last byte
      '{4'd5, 1'b1, 2'd3, 5'd0,  1'b0, 1'b0, 1'b1, 5'd1, 1'b1, 1'b0, 1'b1}, // R5 last byte
      '{4'd5, 1'b1, 2'd3, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R5 idle
      '{4'd7, 1'b0, 2'd0, 5'd15, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R7 level while off
      '{4'd7, 1'b0, 2'd0, 5'd15, 1'b0, 1'b1, 1'b1, 5'd1, 1'b1, 1'b0, 1'b0}, // R7 timeout+drain off
      '{4'd8, 1'b1, 2'd0, 5'd15, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R8 not replayed
      '{4'd6, 1'b1, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R6 held in reset
      '{4'd6, 1'b1, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b1}, // R6 release
      '{4'd7, 1'b0, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0}, // R7 hold while off
      '{4'd7, 1'b0, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}, // R7 release while off
      '{4'd8, 1'b1, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0}  // R8 release lost
   };

   task automatic check(input string tag, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #1;
      check("R9", rx_dma_evt, 1'b0, "rx during reset");
      check("R9", tx_dma_evt, 1'b0, "tx during reset");
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         fifo_en = VECS[i].en;
         rx_trig_sel = VECS[i].sel;
         rx_level = VECS[i].cnt;
         rx_head_err = VECS[i].err;
         rx_timeout = VECS[i].tmo;
         tx_pull = VECS[i].ld;
         tx_level = VECS[i].txc;
         tx_run = VECS[i].run;
         step();
         check($sformatf("R%0d", VECS[i].req), rx_dma_evt, VECS[i].erx, $sformatf("rx vec %0d", i));
         check($sformatf("R%0d", VECS[i].req), tx_dma_evt, VECS[i].etx, $sformatf("tx vec %0d", i));
         @(negedge clk);
      end

      // R9: reset wins over every cause present at the same edge
      fifo_en = 1'b1; rx_trig_sel = 2'd0; rx_level = 5'd9; rx_head_err = 1'b0;
      rx_timeout = 1'b1; tx_pull = 1'b1; tx_level = 5'd1; tx_run = 1'b1;
      rst = 1'b1;
      step();
      check("R9", rx_dma_evt, 1'b0, "rx under reset with causes");
      check("R9", tx_dma_evt, 1'b0, "tx under reset with causes");
      @(negedge clk);
      rx_timeout = 1'b0; tx_pull = 1'b0;
      step();
      @(negedge clk);
      rst = 1'b0;
      // R9: threshold state cleared, so a level already met fires; released tx does not
      step();
      check("R9", rx_dma_evt, 1'b1, "rx after reset with level met");
      check("R9", tx_dma_evt, 1'b0, "tx after reset with run held");
      @(negedge clk);
      step();
      check("R4", rx_dma_evt, 1'b0, "rx no repeat after reset pulse");
      @(negedge clk);

      // R2: back-to-back timeouts each produce a pulse
      rx_level = 5'd0; rx_timeout = 1'b1;
      step();
      check("R2", rx_dma_evt, 1'b1, "first timeout");
      @(negedge clk);
      step();
      check("R2", rx_dma_evt, 1'b1, "second timeout");
      @(negedge clk);
      rx_timeout = 1'b0;
      step();
      check("R2", rx_dma_evt, 1'b0, "timeout removed");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule